// File: doc/BRIEF.md
# Bitfield Shift-and-Merge Unit

This execution unit carries out a single bitfield-move operation that handles both extract and insert. A 64-bit source operand is shifted by a signed amount taken from an immediate. A contiguous mask is built from a low and a high bit bound, both also taken from that immediate. Each result bit takes the shifted source where the mask is set. Elsewhere it takes a second 64-bit operand, called the merge operand.

Supplying zero as the merge operand gives an extract. Supplying the destination's previous contents gives an insert. The unit is a three-stage pipeline with no stalls and accepts one new operation on every cycle. Stage one shifts and builds the mask. Stage two does the masked select. Stage three registers the result and presents it. A valid bit travels with each stage.

Top module: `bitfield_merge_unit`

## Requirements
- R1: When immediate bits [7:0], read as a two's-complement number, lie between 0 and 63, the source is shifted left by that amount and the vacated low bits are zero.
- R2: When immediate bits [7:0] lie between -63 and -1, the source is shifted right logically by the magnitude and the vacated high bits are zero.
- R3: When the shift amount is 64 to 127 or -128 to -64, the shifted value is all zeros, so every masked bit of the result is zero.
- R4: Immediate bits [13:8] give the low bound and bits [19:14] give the high bound. The mask is one exactly on the bits from the low bound through the high bound, both bounds included.
- R5: When the low bound is greater than the high bound, the mask is empty and the result equals the merge operand.
- R6: Each result bit equals the shifted-source bit where the mask is one, and the merge-operand bit where the mask is zero. Extract (merge zero) and insert (merge equals the old destination) both follow from this rule.
- R7: An operation presented with in_valid high in the cycle before rising edge n appears on out_data with out_valid high after rising edge n+2. Back-to-back operations are accepted every cycle, and gaps in in_valid show up as gaps in out_valid.
- R8: A synchronous active-high reset clears every stage valid bit, so out_valid is low after reset until new valid operations have passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the operands and immediate in this cycle |
| in_src | input | 64 | Source operand to be shifted |
| in_merge | input | 64 | Merge operand, used where the mask is zero |
| in_imm | input | 20 | Immediate: shift amount in [7:0], low bound in [13:8], high bound in [19:14] |
| out_valid | output | 1 | Result valid, three cycles after the input |
| out_data | output | 64 | Merged result; don't-care when out_valid is low |

## Verification
The bench sweeps all 256 shift codes and all 4096 bound pairs, including the codes -64, -128, 64 and 127 at the edge of the usable range. A design that wrapped the shift count modulo 64, or that filled from the sign on right shifts, would show stray ones in the masked field. The sweep also checks equal bounds, which must give a one-bit mask, and inverted bounds, which must pass the merge operand through unchanged. An off-by-one at either bound would drop or add an edge bit. Finally, gapped valid patterns and a reset issued while operations are in flight would expose a valid bit that slips a cycle or survives the reset.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  localparam int SHAMT_W = 8;
  localparam int MAG_W   = SHAMT_W + 1;

  typedef struct packed {
    logic             go_right;
    logic [MAG_W-1:0] mag;
  } shamt_t;

  // Split a two's-complement shift code into direction and magnitude.
  function automatic shamt_t decode_shamt(input logic [SHAMT_W-1:0] code);
    shamt_t r;
    int     u;
    u = int'(code);
    r.go_right = code[SHAMT_W-1];
    if (code[SHAMT_W-1]) r.mag = MAG_W'((1 << SHAMT_W) - u);
    else                 r.mag = MAG_W'(u);
    return r;
  endfunction
endpackage

// File: rtl/bfm_stage_prep.sv
module bfm_stage_prep
  import bfm_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int OFF_W = $clog2(DATA_W),
  localparam int IMM_W = SHAMT_W + 2 * OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_merge,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              s1_valid,
  output logic [DATA_W-1:0] s1_shifted,
  output logic [DATA_W-1:0] s1_mask,
  output logic [DATA_W-1:0] s1_merge
);
  function automatic logic [DATA_W-1:0] shift_by(input logic [DATA_W-1:0] v,
                                                 input shamt_t sh);
    if (int'(sh.mag) >= DATA_W) return '0;
    if (sh.go_right)            return v >> sh.mag;
    return v << sh.mag;
  endfunction

  function automatic logic [DATA_W-1:0] span_mask(input logic [OFF_W-1:0] lo,
                                                  input logic [OFF_W-1:0] hi);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++)
      m[i] = (i >= int'(lo)) && (i <= int'(hi));
    return m;
  endfunction

  logic [SHAMT_W-1:0] sh_code;
  logic [OFF_W-1:0]   lo_b, hi_b;
  shamt_t             sh_dec;
  logic               wide_shift;
  logic               bounds_inverted;
  logic [DATA_W-1:0]  shifted_c, mask_c;

  assign sh_code         = in_imm[SHAMT_W-1:0];
  assign lo_b            = in_imm[SHAMT_W +: OFF_W];
  assign hi_b            = in_imm[SHAMT_W+OFF_W +: OFF_W];
  assign sh_dec          = decode_shamt(sh_code);
  assign wide_shift      = int'(sh_dec.mag) >= DATA_W;
  assign bounds_inverted = lo_b > hi_b;
  assign shifted_c       = shift_by(in_src, sh_dec);
  assign mask_c          = span_mask(lo_b, hi_b);

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    s1_shifted <= shifted_c;
    s1_mask    <= mask_c;
    s1_merge   <= in_merge;
  end

  p_wide_shift_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide_shift) |=> (s1_shifted == '0));

  p_inverted_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && bounds_inverted) |=> (s1_mask == '0));

  p_mask_width_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !bounds_inverted) |=>
      ($countones(s1_mask) == int'($past(hi_b)) - int'($past(lo_b)) + 1));

  p_valid_enters_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);
endmodule

// File: rtl/bfm_stage_select.sv
module bfm_stage_select #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic [DATA_W-1:0] s1_shifted,
  input  logic [DATA_W-1:0] s1_mask,
  input  logic [DATA_W-1:0] s1_merge,
  output logic              s2_valid,
  output logic [DATA_W-1:0] s2_data
);
  logic [DATA_W-1:0] pick_c;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign pick_c[b] = s1_mask[b] ? s1_shifted[b] : s1_merge[b];
  end

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
    s2_data <= pick_c;
  end

  p_field_from_shift_r6: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> (((s2_data ^ $past(s1_shifted)) & $past(s1_mask)) == '0));

  p_rest_from_merge_r6: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> (((s2_data ^ $past(s1_merge)) & ~$past(s1_mask)) == '0));

  p_valid_moves_r7: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> s2_valid);
endmodule

// File: rtl/bfm_stage_present.sv
module bfm_stage_present #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s2_valid,
  input  logic [DATA_W-1:0] s2_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s2_valid;
    out_data <= s2_data;
  end

  p_data_carried_r7: assert property (@(posedge clk) disable iff (rst)
    s2_valid |=> (out_valid && out_data == $past(s2_data)));

  p_gap_carried_r7: assert property (@(posedge clk) disable iff (rst)
    !s2_valid |=> !out_valid);

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: rtl/bitfield_merge_unit.sv
module bitfield_merge_unit
  import bfm_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int OFF_W = $clog2(DATA_W),
  localparam int IMM_W = SHAMT_W + 2 * OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_merge,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              s1_valid, s2_valid;
  logic [DATA_W-1:0] s1_shifted, s1_mask, s1_merge, s2_data;

  bfm_stage_prep #(.DATA_W(DATA_W)) u_prep (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
    .in_merge(in_merge), .in_imm(in_imm), .s1_valid(s1_valid),
    .s1_shifted(s1_shifted), .s1_mask(s1_mask), .s1_merge(s1_merge)
  );

  bfm_stage_select #(.DATA_W(DATA_W)) u_select (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_shifted(s1_shifted),
    .s1_mask(s1_mask), .s1_merge(s1_merge), .s2_valid(s2_valid),
    .s2_data(s2_data)
  );

  bfm_stage_present #(.DATA_W(DATA_W)) u_present (
    .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_data(s2_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  p_valid_three_r7: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> ##1 out_valid);
endmodule

// File: tb/tb_bitfield_merge_unit.sv
`timescale 1ns/1ps
module tb_bitfield_merge_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_src = '0, in_merge = '0;
  logic [19:0] in_imm = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic        exp_v [4];
  logic [63:0] exp_d [4];
  string       exp_t [4];
  int          cyc = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #2.5 clk = ~clk;

  bitfield_merge_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
    .in_merge(in_merge), .in_imm(in_imm), .out_valid(out_valid),
    .out_data(out_data)
  );

  // Bit-by-bit model: result bit i comes from source bit i-amt when inside the field.
  function automatic logic [63:0] model(input logic [63:0] s, input logic [63:0] m,
                                        input logic [19:0] imm);
    logic [63:0] r;
    int amt, lo, hi, j;
    amt = int'(imm[7:0]);
    if (amt > 127) amt = amt - 256;
    lo = int'(imm[13:8]);
    hi = int'(imm[19:14]);
    for (int i = 0; i < 64; i++) begin
      j = i - amt;
      if (i >= lo && i <= hi) r[i] = (j >= 0 && j < 64) ? s[j] : 1'b0;
      else                    r[i] = m[i];
    end
    return r;
  endfunction

  function automatic logic [63:0] next_rand();
    rng ^= rng << 13;
    rng ^= rng >> 7;
    rng ^= rng << 17;
    return rng;
  endfunction

  task automatic clear_slots(input string tag);
    for (int k = 0; k < 4; k++) begin
      exp_v[k] = 1'b0;
      exp_d[k] = '0;
      exp_t[k] = tag;
    end
  endtask

  task automatic step(input logic v, input logic [63:0] s, input logic [63:0] m,
                      input logic [19:0] imm, input string tag);
    int rd, wr;
    @(negedge clk);
    rd = (cyc + 1) % 4;
    wr = cyc % 4;
    checks++;
    if (out_valid !== exp_v[rd]) begin
      errors++;
      $display("FAIL %s: out_valid=%b expected %b (cycle %0d)", exp_t[rd], out_valid,
               exp_v[rd], cyc);
    end
    if (exp_v[rd]) begin
      checks++;
      if (out_data !== exp_d[rd]) begin
        errors++;
        $display("FAIL %s: out_data=%h expected %h (cycle %0d)", exp_t[rd], out_data,
                 exp_d[rd], cyc);
      end
    end
    in_valid = v;
    in_src   = s;
    in_merge = m;
    in_imm   = imm;
    exp_v[wr] = v;
    exp_d[wr] = model(s, m, imm);
    exp_t[wr] = tag;
    cyc++;
  endtask

  task automatic drain(input string tag);
    repeat (4) step(1'b0, '0, '0, '0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_slots("R8");
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] srcs [3];
    string tg;
    clear_slots("R8");
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: valid stays low coming out of reset
    drain("R8");

    // R1 R2 R3: every shift code with a full-width field
    srcs[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    srcs[1] = 64'h8000_0000_0000_0001;
    srcs[2] = 64'hA5C3_0F96_1E2D_3C4B;
    for (int s = 0; s < 3; s++) begin
      for (int a = -128; a < 128; a++) begin
        if (a >= 0 && a < 64)      tg = "R1";
        else if (a < 0 && a > -64) tg = "R2";
        else                       tg = "R3";
        step(1'b1, srcs[s], 64'h5555_AAAA_5555_AAAA, {6'd63, 6'd0, 8'(a)}, tg);
      end
    end
    drain("R3");

    // R4 R5: every bound pair, no shift, all-ones source, merge zero (extract)
    for (int lo = 0; lo < 64; lo++)
      for (int hi = 0; hi < 64; hi++)
        step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, '0, {6'(hi), 6'(lo), 8'd0},
             (lo > hi) ? "R5" : "R4");
    // R5: inverted bounds on an insert keep the old destination
    for (int k = 0; k < 32; k++)
      step(1'b1, next_rand(), next_rand(), {6'(k), 6'(k + 1), next_rand()[7:0]}, "R5");
    drain("R5");

    // R6: mixed extract and insert with arbitrary immediates
    for (int k = 0; k < 1500; k++) begin
      logic [63:0] s, m;
      s = next_rand();
      m = (k % 2 == 0) ? 64'd0 : next_rand();
      step(1'b1, s, m, next_rand()[19:0], "R6");
    end
    drain("R6");

    // R7: gapped valid patterns
    for (int k = 0; k < 200; k++)
      step(((k % 3) == 1) || ((k % 7) == 0), next_rand(), next_rand(),
           next_rand()[19:0], "R7");
    drain("R7");

    // R8: reset with operations in flight
    step(1'b1, next_rand(), next_rand(), next_rand()[19:0], "R8");
    step(1'b1, next_rand(), next_rand(), next_rand()[19:0], "R8");
    do_reset();
    drain("R8");
    step(1'b1, 64'h0123_4567_89AB_CDEF, '0, {6'd15, 6'd4, 8'hFC}, "R8");
    drain("R8");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule